// File: doc/BRIEF.md
# Programmable Mask-Encoded Chip Select Decoder

This block turns a 28-bit local bus address into four active-low chip select outputs, one per attached device. Each output has its own 28-bit configuration word, loaded through a small register write port. Bit 0 of the word turns the select on. The lowest set bit above bit 0 gives the window size. Every bit above that one is the window base. Because base and size share one word, no separate mask register is needed. The compare mask follows from where the size bit sits.

The address path is purely combinational, and only the configuration is registered. A separate input says whether some local address space has claimed the current address. No select ever fires for an unclaimed address. The four channels decode independently, so overlapping windows assert more than one select at once, with no priority between them.

The write port is a plain strobe with no handshake. It has no back-pressure: every write is accepted, and it takes effect at the next rising clock edge. The address and claim inputs are sampled continuously and have no valid/ready pairing.

Top module: `csel_decoder_top`

## Requirements
- R1: The four channels decode independently. When the windows of several enabled channels contain the same claimed address, all of their `csel_n` bits are low together, with no priority.
- R2: When `cfg_we` is 1 at a rising edge, configuration word `cfg_idx` (0 to 3) takes `cfg_data`, and the outputs reflect it from that edge on. Words with another index are unchanged. A value driven before the edge has no effect until the edge.
- R3: When `addr_claimed` is 0, all `csel_n` bits are 1, whatever the address and configuration.
- R4: When bit 0 (enable) of a channel's word is 0, that channel's `csel_n` bit is 1.
- R5: Let k be the position of the lowest set bit among word bits 27..1. The window is then 2^(k+1) bytes. The channel asserts (drives 0) when `bus_addr[27:k+1]` equals word bits 27..k+1. Address bits k..0 are ignored, and the base is used unshifted.
- R6: A word with the enable set and bits 27..1 all zero is an invalid window, and its channel never asserts.
- R7: During and after reset, all four words are zero, and all `csel_n` bits are 1 until a word is written.
- R8: A word with bit 27 as its lowest set bit above bit 0 (for example 0x8000001) matches every claimed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_idx | input | 2 | Index of the word to write |
| cfg_data | input | 28 | Value to write: enable in bit 0, size bit, base above it |
| bus_addr | input | 28 | Local bus address to decode |
| addr_claimed | input | 1 | 1 when a local address space has claimed `bus_addr` |
| csel_n | output | 4 | Active-low chip selects, bit i for channel i |

## Verification
The main decode is driven with addresses placed just inside, at both edges of, and just past windows of known size. A wrong size bit or a shifted base shows up as a miss at an edge, or as a hit one window too far. The same hitting address is replayed with the claim input low, with the enable cleared and with an empty size field. This separates each gating term from the compare itself. Overlapping and whole-space windows show whether channels interfere with each other. Random aligned windows, with addresses scattered around their bases, cover the size positions that the directed cases skip.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // number of chip select channels
  parameter int unsigned CSEL_NUM = 4;
  // width of the decoded address and of each configuration word
  parameter int unsigned CSEL_W   = 28;
  localparam int unsigned CSEL_IDX_W = (CSEL_NUM > 1) ? $clog2(CSEL_NUM) : 1;

  typedef logic [CSEL_W-1:0] csel_word_t;

  // decoded form of one configuration word
  typedef struct packed {
    logic       valid;   // a size bit exists above bit 0
    csel_word_t cmp_msk; // 1 where address bits take part in the compare
  } csel_win_t;
endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
  import csel_pkg::*;
#(
  parameter int unsigned NUM_SEL = CSEL_NUM,
  parameter int unsigned IDX_W   = CSEL_IDX_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [CSEL_W-1:0]              wr_data,
  output logic [NUM_SEL-1:0][CSEL_W-1:0] cfg_q
);

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_word
    logic hit_idx;
    assign hit_idx = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q[i] <= '0;
      else if (hit_idx) cfg_q[i] <= wr_data;
    end

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=> (cfg_q[i] == $past(wr_data)));

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(cfg_q[i]));

    // R7
    rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n)) |-> (cfg_q[i] == '0));
  end

endmodule

// File: rtl/csel_window_mask.sv
module csel_window_mask
  import csel_pkg::*;
(
  input  csel_word_t cfg_i,
  output csel_win_t  win_o
);

  // mask bit b is set when some word bit in [b-1:1] is set,
  // i.e. when b lies strictly above the lowest size bit
  always_comb begin
    logic run;
    run = 1'b0;
    win_o.cmp_msk = '0;
    for (int b = 1; b < CSEL_W; b++) begin
      win_o.cmp_msk[b] = run;
      run = run | cfg_i[b];
    end
    win_o.valid = run;
  end

endmodule

// File: rtl/csel_window_match.sv
module csel_window_match
  import csel_pkg::*;
(
  input  csel_word_t cfg_i,
  input  csel_word_t addr_i,
  input  logic       claimed_i,
  output logic       sel_o
);

  csel_win_t win;

  csel_window_mask u_mask (
    .cfg_i (cfg_i),
    .win_o (win)
  );

  logic in_win;
  assign in_win = ~|((addr_i ^ cfg_i) & win.cmp_msk);
  assign sel_o  = cfg_i[0] & win.valid & claimed_i & in_win;

endmodule

// File: rtl/csel_decoder_top.sv
module csel_decoder_top
  import csel_pkg::*;
#(
  parameter int unsigned NUM_SEL = CSEL_NUM,
  parameter int unsigned IDX_W   = CSEL_IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [CSEL_W-1:0]  cfg_data,
  input  logic [CSEL_W-1:0]  bus_addr,
  input  logic               addr_claimed,
  output logic [NUM_SEL-1:0] csel_n
);

  logic [NUM_SEL-1:0][CSEL_W-1:0] cfg_w;
  logic [NUM_SEL-1:0]             sel;

  csel_cfg_regs #(
    .NUM_SEL (NUM_SEL),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_data),
    .cfg_q   (cfg_w)
  );

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_ch
    csel_window_match u_match (
      .cfg_i     (cfg_w[i]),
      .addr_i    (bus_addr),
      .claimed_i (addr_claimed),
      .sel_o     (sel[i])
    );

    assign csel_n[i] = ~sel[i];

    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_w[i][0] |-> csel_n[i]);

    // R6
    empty_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_w[i][CSEL_W-1:1] == '0) |-> csel_n[i]);

    // R8
    whole_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_w[i] == {1'b1, {(CSEL_W-2){1'b0}}, 1'b1} && addr_claimed) |-> !csel_n[i]);
  end

  // R3
  unclaimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_claimed |-> (&csel_n));

endmodule

// File: tb/csel_decoder_top_tb_top.sv
module csel_decoder_top_tb_top;
  localparam int W = 28;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_idx = '0;
  logic [W-1:0] cfg_data = '0;
  logic [W-1:0] bus_addr = '0;
  logic         addr_claimed = 1'b0;
  logic [N-1:0] csel_n;

  int unsigned vec_cnt = 0;
  int unsigned err_cnt = 0;
  bit          done = 1'b0;
  logic [W-1:0] shadow [N];

  always #10 clk = ~clk; // 50 MHz

  csel_decoder_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_idx      (cfg_idx),
    .cfg_data     (cfg_data),
    .bus_addr     (bus_addr),
    .addr_claimed (addr_claimed),
    .csel_n       (csel_n)
  );

  // lowest set bit in word bits 27..1, or 0 if none
  function automatic int low_bit(input logic [W-1:0] w);
    for (int b = 1; b < W; b++) if (w[b]) return b;
    return 0;
  endfunction

  function automatic logic [N-1:0] model(input logic [W-1:0] a, input logic cl);
    logic [N-1:0] r;
    r = '1;
    for (int c = 0; c < N; c++) begin
      int k;
      k = low_bit(shadow[c]);
      if (cl && shadow[c][0] && k != 0)
        if ((32'(a) >> (k + 1)) == (32'(shadow[c]) >> (k + 1))) r[c] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    vec_cnt++;
    if (got !== exp) begin
      err_cnt++;
      $display("FAIL %s: csel_n=%b expected %b (addr=%h claimed=%b)",
               tag, got, exp, bus_addr, addr_claimed);
    end
  endtask

  task automatic wr(input int idx, input logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[idx] = d;
  endtask

  task automatic probe(input string tag, input logic [W-1:0] a, input logic cl);
    @(negedge clk);
    bus_addr = a; addr_claimed = cl;
    #5;
    check(tag, csel_n, model(a, cl));
  endtask

  function automatic logic [W-1:0] rand_word();
    int k;
    logic [31:0] base;
    k = $urandom_range(W - 1, 1);
    base = $urandom() & ~((32'd1 << (k + 1)) - 1);
    return W'(base) | W'(32'd1 << k) | W'($urandom_range(9, 0) < 8);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      vec_cnt++; err_cnt++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < N; c++) shadow[c] = '0;
    bus_addr = 28'h0001234; addr_claimed = 1'b1;
    #15;
    check("R7 in reset", csel_n, 4'hF);
    @(negedge clk); rst_n = 1'b1;
    probe("R7 after reset", 28'h0000000, 1'b1);
    probe("R7 after reset", 28'h0001234, 1'b1);

    // 4 KiB window at 0x0001000: size bit 11
    wr(0, 28'h0001801);
    probe("R5 inside", 28'h0001234, 1'b1);
    check("R5 inside value", csel_n, 4'b1110);
    probe("R5 low edge", 28'h0001000, 1'b1);
    probe("R5 high edge", 28'h0001FFF, 1'b1);
    probe("R5 below", 28'h0000FFF, 1'b1);
    check("R5 below value", csel_n, 4'b1111);
    probe("R5 above", 28'h0002000, 1'b1);
    probe("R3 unclaimed", 28'h0001234, 1'b0);
    check("R3 value", csel_n, 4'b1111);

    wr(1, 28'h0001800);
    probe("R4 disabled", 28'h0001234, 1'b1);
    check("R4 value", csel_n, 4'b1110);
    wr(1, 28'h0001801);
    probe("R1 overlap", 28'h0001234, 1'b1);
    check("R1 value", csel_n, 4'b1100);

    wr(2, 28'h0000001);
    probe("R6 empty window", 28'h0000000, 1'b1);
    probe("R6 empty window", 28'h0001234, 1'b1);
    check("R6 value", csel_n, 4'b1100);

    wr(3, 28'h8000001);
    probe("R8 whole space", 28'hFFFFFFF, 1'b1);
    check("R8 value", csel_n, 4'b0111);
    probe("R8 whole space", 28'h0000000, 1'b1);

    // R2: value on the port before the edge has no effect yet
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_data = 28'h0001800;
    bus_addr = 28'h0001234; addr_claimed = 1'b1;
    #5;
    check("R2 before edge", csel_n, 4'b0100);
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[0] = 28'h0001800;
    #5;
    check("R2 after edge", csel_n, 4'b0101);
    probe("R2 others kept", 28'h0001234, 1'b1);

    // random windows and addresses around them
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(3, 0) == 0) begin
        int c;
        c = $urandom_range(N - 1, 0);
        wr(c, ($urandom_range(19, 0) == 0) ? W'($urandom_range(1, 0)) : rand_word());
      end
      begin
        int c, k;
        logic [31:0] a;
        c = $urandom_range(N - 1, 0);
        k = low_bit(shadow[c]);
        if (k != 0 && k < W - 1)
          a = 32'(shadow[c]) ^ ($urandom() & ((32'd1 << (k + 2)) - 1));
        else
          a = $urandom();
        probe("R5 random", W'(a), $urandom_range(9, 0) != 0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule